// File: doc/BRIEF.md
# DMA Request Arbiter

This block sits in front of a DMA transfer engine and chooses the channel the engine serves next. Every channel offers two peripheral request lines, one for single transfers and one for bursts, plus a software request pulse. Per-channel control vectors give the channel enable, a mask for the peripheral lines, a burst-only mode and a high-priority flag. A master enable gates the whole arbiter.

Requests are qualified per channel and one winner is taken at a time. The winner comes from the high-priority group if any channel there is requesting, and otherwise from the default group. The lowest channel number wins inside a group. The grant is registered and held until the engine pulses slot-done. A channel that has wait-on-request set keeps its active flag after slot-done for as long as either of its request lines is still high. No new grant is issued during that time.

Top module: `dma_req_arbiter`

## Requirements
- R1: When a channel's `use_burst_i` bit is 1, a high `sreq_i` on that channel never produces a grant for it. Only `breq_i` counts for that channel.
- R2: When a channel's `use_burst_i` bit is 0, either `sreq_i` or `breq_i` on that channel makes it a candidate for a grant.
- R3: When a channel's `req_mask_i` bit is 1, both of its peripheral request lines are ignored. A software request on that channel is still served.
- R4: A 1 on bit c of `sw_req_i`, for c < NUM_CH, is latched until channel c is granted. Bits of `sw_req_i` at NUM_CH and above create no request.
- R5: A requesting channel whose `hi_prio_i` bit is 1 is granted ahead of every requesting channel whose bit is 0.
- R6: Within one priority group, the lowest-numbered requesting channel is granted.
- R7: Only channels whose `ch_en_i` bit is 1 are granted. No grant is issued while `master_en_i` is 0.
- R8: A grant shows `grant_valid_o`=1, a one-hot `grant_oh_o` and the matching `grant_idx_o`. These values stay unchanged until the cycle after `slot_done_i` is sampled high, and then `grant_valid_o` falls.
- R9: `active_o` equals `grant_oh_o` while a grant is valid. If the granted channel has its `wait_req_i` bit set and `sreq_i` or `breq_i` is still high when slot-done is sampled, its `active_o` bit stays 1 and no grant is issued until both lines are low. `active_o` is never more than one-hot.
- R10: After reset all outputs are 0. A channel that qualifies while the arbiter is idle is granted on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_en_i | input | 1 | Global enable for granting |
| ch_en_i | input | NUM_CH | Per-channel enable |
| req_mask_i | input | NUM_CH | 1 masks the channel's peripheral request lines |
| use_burst_i | input | NUM_CH | 1 makes the channel ignore single requests |
| hi_prio_i | input | NUM_CH | 1 places the channel in the high-priority group |
| wait_req_i | input | NUM_CH | 1 holds the channel active until its requests drop |
| sreq_i | input | NUM_CH | Peripheral single-transfer requests |
| breq_i | input | NUM_CH | Peripheral burst requests |
| sw_req_i | input | SW_W | Software request pulses, one bit per channel |
| slot_done_i | input | 1 | Engine pulse that ends the current grant |
| grant_valid_o | output | 1 | A grant is being held |
| grant_oh_o | output | NUM_CH | One-hot granted channel, zero when no grant is held |
| grant_idx_o | output | max(1,$clog2(NUM_CH)) | Index of the granted channel |
| active_o | output | NUM_CH | Channel currently occupying the engine |

## Verification
Directed patterns isolate one rule at a time:
- A single request on a burst-only channel shows whether the use-burst bit is honoured.
- A masked channel that has both a burst line and a software pulse separates the peripheral path from the software path.
- A pulse on an unimplemented bit shows that no request appears out of range.
- Two concurrent requesters with differing or equal priority distinguish priority order from index order.
- A wait-on-request channel whose line stays high after slot-done shows that the active flag is held and that further grants are blocked.

Seeded random traffic then mixes every control vector with random slot-done timing. It is compared cycle by cycle against a reference model, which catches errors in hold and release timing that the directed cases do not reach.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_BUSY = 2'd1,
    ARB_HOLD = 2'd2
  } arb_st_e;
endpackage

// File: rtl/dma_req_qual.sv
`timescale 1ns/1ps
module dma_req_qual #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned SW_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_en_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_CH-1:0] req_mask_i,
  input  logic [NUM_CH-1:0] use_burst_i,
  input  logic [NUM_CH-1:0] sreq_i,
  input  logic [NUM_CH-1:0] breq_i,
  input  logic [SW_W-1:0]   sw_req_i,
  input  logic [NUM_CH-1:0] pend_clr_i,
  output logic [NUM_CH-1:0] cand_o,
  output logic [NUM_CH-1:0] ext_raw_o
);
  logic [NUM_CH-1:0] sw_set;
  logic [NUM_CH-1:0] sw_pend_q;
  logic [NUM_CH-1:0] ext_req;

  // bits beyond the implemented channels are dropped
  generate
    if (SW_W > NUM_CH) begin : g_sw_wide
      logic sw_hi_unused;
      assign sw_set       = sw_req_i[NUM_CH-1:0];
      assign sw_hi_unused = |sw_req_i[SW_W-1:NUM_CH];
    end else if (SW_W == NUM_CH) begin : g_sw_eq
      assign sw_set = sw_req_i;
    end else begin : g_sw_narrow
      assign sw_set = {{(NUM_CH-SW_W){1'b0}}, sw_req_i};
    end
  endgenerate

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic single_ok;
      assign single_ok    = sreq_i[c] & ~use_burst_i[c];
      assign ext_req[c]   = ~req_mask_i[c] & (breq_i[c] | single_ok);
      assign ext_raw_o[c] = sreq_i[c] | breq_i[c];
      assign cand_o[c]    = master_en_i & ch_en_i[c] & (ext_req[c] | sw_pend_q[c]);
    end
  endgenerate

  // set wins over clear when both hit the same channel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_pend_q <= '0;
    else         sw_pend_q <= (sw_pend_q & ~pend_clr_i) | sw_set;
  end
endmodule

// File: rtl/dma_prio_pick.sv
`timescale 1ns/1ps
module dma_prio_pick #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] cand_i,
  input  logic [NUM_CH-1:0] hi_prio_i,
  output logic              any_o,
  output logic [NUM_CH-1:0] pick_oh_o,
  output logic [CH_W-1:0]   pick_idx_o
);
  logic [NUM_CH-1:0] hi_cand;
  logic [NUM_CH-1:0] sel;

  assign hi_cand = cand_i & hi_prio_i;
  assign sel     = (|hi_cand) ? hi_cand : cand_i;
  assign any_o   = |cand_i;

  // descending scan: last hit is the lowest index
  always_comb begin
    pick_oh_o  = '0;
    pick_idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (sel[i]) begin
        pick_oh_o  = NUM_CH'(1) << i;
        pick_idx_o = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/dma_grant_ctrl.sv
`timescale 1ns/1ps
module dma_grant_ctrl
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_i,
  input  logic [NUM_CH-1:0] pick_oh_i,
  input  logic [CH_W-1:0]   pick_idx_i,
  input  logic              slot_done_i,
  input  logic [NUM_CH-1:0] wait_req_i,
  input  logic [NUM_CH-1:0] ext_raw_i,
  output logic              issue_o,
  output logic              grant_valid_o,
  output logic [NUM_CH-1:0] grant_oh_o,
  output logic [CH_W-1:0]   grant_idx_o,
  output logic [NUM_CH-1:0] active_o
);
  arb_st_e           st_q, st_d;
  logic [NUM_CH-1:0] held_oh_q;
  logic [CH_W-1:0]   held_idx_q;
  logic              held_wait;
  logic              held_req;

  assign held_wait = |(held_oh_q & wait_req_i);
  assign held_req  = |(held_oh_q & ext_raw_i);
  assign issue_o   = (st_q == ARB_IDLE) && any_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ARB_IDLE: if (any_i) st_d = ARB_BUSY;
      ARB_BUSY: if (slot_done_i) st_d = (held_wait && held_req) ? ARB_HOLD : ARB_IDLE;
      ARB_HOLD: if (!held_req) st_d = ARB_IDLE;
      default:  st_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ARB_IDLE;
      held_oh_q  <= '0;
      held_idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (issue_o) begin
        held_oh_q  <= pick_oh_i;
        held_idx_q <= pick_idx_i;
      end
    end
  end

  assign grant_valid_o = (st_q == ARB_BUSY);
  assign grant_oh_o    = grant_valid_o ? held_oh_q : '0;
  assign grant_idx_o   = held_idx_q;
  assign active_o      = (st_q != ARB_IDLE) ? held_oh_q : '0;
endmodule

// File: rtl/dma_req_arbiter.sv
`timescale 1ns/1ps
module dma_req_arbiter #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned SW_W   = 32,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_en_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_CH-1:0] req_mask_i,
  input  logic [NUM_CH-1:0] use_burst_i,
  input  logic [NUM_CH-1:0] hi_prio_i,
  input  logic [NUM_CH-1:0] wait_req_i,
  input  logic [NUM_CH-1:0] sreq_i,
  input  logic [NUM_CH-1:0] breq_i,
  input  logic [SW_W-1:0]   sw_req_i,
  input  logic              slot_done_i,
  output logic              grant_valid_o,
  output logic [NUM_CH-1:0] grant_oh_o,
  output logic [CH_W-1:0]   grant_idx_o,
  output logic [NUM_CH-1:0] active_o
);
  logic [NUM_CH-1:0] cand;
  logic [NUM_CH-1:0] ext_raw;
  logic [NUM_CH-1:0] pick_oh;
  logic [CH_W-1:0]   pick_idx;
  logic              any;
  logic              issue;
  logic [NUM_CH-1:0] pend_clr;

  assign pend_clr = issue ? pick_oh : '0;

  dma_req_qual #(.NUM_CH(NUM_CH), .SW_W(SW_W)) u_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .master_en_i (master_en_i),
    .ch_en_i     (ch_en_i),
    .req_mask_i  (req_mask_i),
    .use_burst_i (use_burst_i),
    .sreq_i      (sreq_i),
    .breq_i      (breq_i),
    .sw_req_i    (sw_req_i),
    .pend_clr_i  (pend_clr),
    .cand_o      (cand),
    .ext_raw_o   (ext_raw)
  );

  dma_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
    .cand_i     (cand),
    .hi_prio_i  (hi_prio_i),
    .any_o      (any),
    .pick_oh_o  (pick_oh),
    .pick_idx_o (pick_idx)
  );

  dma_grant_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .any_i         (any),
    .pick_oh_i     (pick_oh),
    .pick_idx_i    (pick_idx),
    .slot_done_i   (slot_done_i),
    .wait_req_i    (wait_req_i),
    .ext_raw_i     (ext_raw),
    .issue_o       (issue),
    .grant_valid_o (grant_valid_o),
    .grant_oh_o    (grant_oh_o),
    .grant_idx_o   (grant_idx_o),
    .active_o      (active_o)
  );
endmodule

// File: rtl/dma_req_arbiter_chk.sv
`timescale 1ns/1ps
module dma_req_arbiter_chk #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_en_i,
  input logic              slot_done_i,
  input logic              grant_valid_o,
  input logic [NUM_CH-1:0] grant_oh_o,
  input logic [CH_W-1:0]   grant_idx_o,
  input logic [NUM_CH-1:0] active_o
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> $countones(grant_oh_o) == 1); // R8
  AST_GRANT_IDX_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> grant_oh_o[grant_idx_o]); // R8
  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o && !slot_done_i |=> grant_valid_o && $stable(grant_oh_o) && $stable(grant_idx_o)); // R8
  AST_GRANT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o && slot_done_i |=> !grant_valid_o); // R8
  AST_NO_GRANT_MASTER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_valid_o && !master_en_i |=> !grant_valid_o); // R7
  AST_ACTIVE_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(active_o)); // R9
  AST_ACTIVE_TRACKS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> active_o == grant_oh_o); // R9
  AST_WAIT_BLOCKS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_valid_o && (|active_o) |=> !grant_valid_o); // R9
  AST_IDLE_ZERO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_valid_o |-> grant_oh_o == '0); // R10
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/dma_req_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb_top;
  localparam int N  = 8;
  localparam int SW = 32;
  localparam int IW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          master_en_i = 1'b0;
  logic [N-1:0]  ch_en_i = '0, req_mask_i = '0, use_burst_i = '0, hi_prio_i = '0;
  logic [N-1:0]  wait_req_i = '0, sreq_i = '0, breq_i = '0;
  logic [SW-1:0] sw_req_i = '0;
  logic          slot_done_i = 1'b0;
  logic          grant_valid_o;
  logic [N-1:0]  grant_oh_o, active_o;
  logic [IW-1:0] grant_idx_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  dma_req_arbiter #(.NUM_CH(N), .SW_W(SW)) dut_i (.*);

  // reference model: 0 idle, 1 granted, 2 waiting for requests to drop
  int           m_st = 0;
  logic [N-1:0] m_pend = '0;
  logic [N-1:0] m_oh = '0;

  function automatic logic [N-1:0] f_pick(input logic [N-1:0] c, input logic [N-1:0] h);
    logic [N-1:0] s;
    s = (|(c & h)) ? (c & h) : c;
    for (int i = 0; i < N; i++) if (s[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic int f_idx(input logic [N-1:0] oh);
    for (int i = 0; i < N; i++) if (oh[i]) return i;
    return 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_pend = '0; m_oh = '0;
    end else begin
      logic [N-1:0] cand, ext, clr;
      logic held_req;
      ext  = ~req_mask_i & (breq_i | (sreq_i & ~use_burst_i));
      cand = master_en_i ? (ch_en_i & (ext | m_pend)) : '0;
      clr  = '0;
      held_req = |(m_oh & (sreq_i | breq_i));
      case (m_st)
        0: if (|cand) begin m_oh = f_pick(cand, hi_prio_i); clr = m_oh; m_st = 1; end
        1: if (slot_done_i) m_st = (|(m_oh & wait_req_i) && held_req) ? 2 : 0;
        default: if (!held_req) m_st = 0;
      endcase
      m_pend = (m_pend & ~clr) | sw_req_i[N-1:0];
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_model();
    logic [N-1:0] e_oh, e_act;
    e_oh  = (m_st == 1) ? m_oh : '0;
    e_act = (m_st != 0) ? m_oh : '0;
    chk(grant_valid_o == (m_st == 1), "R8", "grant_valid", grant_valid_o, m_st == 1);
    chk(grant_oh_o == e_oh, "R8", "grant_oh", grant_oh_o, e_oh);
    if (m_st == 1) chk(int'(grant_idx_o) == f_idx(m_oh), "R8", "grant_idx", grant_idx_o, f_idx(m_oh));
    chk(active_o == e_act, "R9", "active", active_o, e_act);
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk_i);
      cmp_model();
    end
  endtask

  task automatic finish_slot();
    slot_done_i = 1'b1;
    step(1);
    slot_done_i = 1'b0;
    step(1);
  endtask

  task automatic clear_all();
    ch_en_i = '0; req_mask_i = '0; use_burst_i = '0; hi_prio_i = '0;
    wait_req_i = '0; sreq_i = '0; breq_i = '0; sw_req_i = '0; slot_done_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step(1);
    chk(grant_valid_o == 1'b0 && active_o == '0 && grant_oh_o == '0, "R10", "reset outputs",
        {grant_valid_o, active_o, grant_oh_o}, 0);

    master_en_i = 1'b1;
    // R1: single request ignored on a burst-only channel
    ch_en_i = 8'h04; use_burst_i = 8'h04; sreq_i = 8'h04;
    step(5);
    chk(grant_valid_o == 1'b0, "R1", "single on burst-only", grant_valid_o, 0);
    // R2: same single request accepted once use-burst is 0; granted one edge later (R10)
    use_burst_i = '0;
    step(1);
    chk(grant_valid_o && grant_idx_o == 3'd2, "R2", "single accepted idx", grant_idx_o, 2);
    chk(grant_valid_o, "R10", "grant one edge after qualify", grant_valid_o, 1);
    // R8: grant held while requests change
    sreq_i = '0; breq_i = 8'h01; ch_en_i = 8'h05;
    step(3);
    chk(grant_valid_o && grant_oh_o == 8'h04, "R8", "grant held", grant_oh_o, 8'h04);
    finish_slot();
    clear_all();
    finish_slot();
    step(2);

    // R3: masked peripheral lines ignored, software request still served (R4)
    ch_en_i = 8'h08; req_mask_i = 8'h08; breq_i = 8'h08;
    step(4);
    chk(grant_valid_o == 1'b0, "R3", "masked burst", grant_valid_o, 0);
    sw_req_i = 32'h8;
    step(1);
    sw_req_i = '0;
    step(1);
    chk(grant_valid_o && grant_idx_o == 3'd3, "R4", "software req latched", grant_idx_o, 3);
    finish_slot();
    step(3);
    chk(grant_valid_o == 1'b0, "R4", "pending cleared by grant", grant_valid_o, 0);
    clear_all();
    // R4: out-of-range software bit
    ch_en_i = 8'hFF; sw_req_i = 32'h0010_0000;
    step(1);
    sw_req_i = '0;
    step(4);
    chk(grant_valid_o == 1'b0, "R4", "unimplemented channel", grant_valid_o, 0);

    // R5: high priority beats lower index
    breq_i = 8'h42; hi_prio_i = 8'h40;
    step(1);
    chk(grant_idx_o == 3'd6, "R5", "high priority wins", grant_idx_o, 6);
    breq_i = 8'h28; hi_prio_i = '0;
    finish_slot();
    // R6: lowest index inside one group
    chk(grant_valid_o && grant_idx_o == 3'd3, "R6", "lowest index", grant_idx_o, 3);
    finish_slot();
    // R7: disabled channels and master off
    clear_all();
    finish_slot();
    ch_en_i = 8'hEF; breq_i = 8'h10;
    step(4);
    chk(grant_valid_o == 1'b0, "R7", "disabled channel", grant_valid_o, 0);
    ch_en_i = 8'hFF; master_en_i = 1'b0;
    step(4);
    chk(grant_valid_o == 1'b0, "R7", "master off", grant_valid_o, 0);
    master_en_i = 1'b1;
    step(1);
    chk(grant_idx_o == 3'd4, "R7", "master on grant", grant_idx_o, 4);

    // R9: wait-on-request hold
    wait_req_i = 8'h10; breq_i = 8'h11;
    finish_slot();
    chk(active_o == 8'h10 && !grant_valid_o, "R9", "active held after done", active_o, 8'h10);
    step(3);
    chk(active_o == 8'h10 && !grant_valid_o, "R9", "no grant while held", grant_valid_o, 0);
    breq_i = 8'h01;
    step(1);
    chk(active_o == '0, "R9", "active drops with request", active_o, 0);
    step(1);
    chk(grant_idx_o == 3'd0 && grant_valid_o, "R9", "next grant after release", grant_idx_o, 0);
    finish_slot();
    clear_all();
    finish_slot();

    // seeded random traffic against the model
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc % 40 == 0) begin
        ch_en_i     = N'($urandom) | N'($urandom);
        req_mask_i  = N'($urandom) & N'($urandom);
        use_burst_i = N'($urandom);
        hi_prio_i   = N'($urandom) & N'($urandom);
        wait_req_i  = N'($urandom);
        master_en_i = ($urandom % 8) != 0;
      end
      sreq_i      = N'($urandom) & N'($urandom);
      breq_i      = N'($urandom) & N'($urandom) & N'($urandom);
      sw_req_i    = (($urandom % 6) == 0) ? SW'($urandom) : '0;
      slot_done_i = ($urandom % 3) == 0;
      step(1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule